// File: doc/BRIEF.md
# Bidirectional Handshaked Parallel Port

This block is one 8-bit parallel port that moves bytes in both directions over a single set of pins. Outgoing bytes written by the CPU wait in an output holding register. The port pins are driven only while the peripheral pulls its acknowledge line low. Incoming bytes are captured from the pins while the peripheral holds its strobe line low. They wait in a separate input holding register until the CPU reads them. Two flags tell the peripheral and the CPU the state of each register: an active-low "output full" line and an active-high "input full" line.

Each direction has its own interrupt enable. The CPU sets or clears an enable with a one-bit command, and both directions share one interrupt request line. The CPU side is a two-location register interface with active-low read and write strobes. Location 0 is the data register and location 1 is the command/status register.

All four strobes are asynchronous. Each passes through a two-stage synchronizer, and the block acts on the edges it sees after synchronization. The pin data goes through a synchronizer of the same depth, so that captured data stays aligned with the strobe. As a result, every effect appears on the outputs three clock edges after the strobe changes.

Top module: `bidir_hs_port`

## Requirements
- R1: A write to address 0 loads `cpu_wdata` into the output register on the rising edge of `cpu_wr_n` and drives `obf_n` low at that point. The falling edge of `cpu_wr_n` alone does not lower `obf_n`.
- R2: A falling edge on `ack_n` returns `obf_n` high.
- R3: `pin_oe` is high only while `ack_n` is low, and during that time `pin_out` carries the output register. Otherwise `pin_oe` is low, meaning the pins float.
- R4: While `stb_n` is low, the input register follows `pin_in`. It keeps the last value seen before `stb_n` rose, and a read of address 0 returns that value on `cpu_rdata`.
- R5: `ibf` rises on the falling edge of `stb_n`. It stays high through a read until the rising edge of `cpu_rd_n` for address 0, where it falls.
- R6: The output-side request is set on the rising edge of `ack_n` when `obf_n` is high and the output enable is set. It is cleared on the falling edge of `cpu_wr_n` for address 0.
- R7: The input-side request is set on the rising edge of `stb_n` when `ibf` is high and the input enable is set. It is cleared on the falling edge of `cpu_rd_n` for address 0, and a read of address 1 leaves it untouched.
- R8: A write to address 1 is a command. `cpu_wdata[1]` picks the enable (0 = output, 1 = input) and `cpu_wdata[0]` is its new value. Clearing an enable withdraws that side's pending request. `intr` is the OR of the two pending requests, so it stays high while either one remains.
- R9: A read of address 1 returns a status byte with these fields:
  - bit 7: the `obf_n` level
  - bit 6: the output enable
  - bit 5: `ibf`
  - bit 4: the input enable
  - bit 3: `intr`
  - bits 2:0: zero
- R10: Synchronous reset clears both holding registers and both enables, and returns the port to its idle state:
  - `obf_n` high, `ibf` low, `intr` low and `pin_oe` low
  - a status read returns 0x80

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 1 | 0 = data register, 1 = command/status register |
| cpu_wr_n | input | 1 | CPU write strobe, active low, asynchronous |
| cpu_rd_n | input | 1 | CPU read strobe, active low, asynchronous |
| cpu_wdata | input | 8 | Write data from the CPU |
| cpu_rdata | output | 8 | Read data, registered on the read strobe's falling edge |
| pin_in | input | 8 | Port pin input levels |
| pin_out | output | 8 | Port pin output values |
| pin_oe | output | 1 | Port pin drive enable (0 = high impedance) |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Output register full, active low |
| ibf | output | 1 | Input register full, active high |
| intr | output | 1 | Combined interrupt request |

## Verification
The bench changes the pin data at the same moment the strobe rises. A design whose pin path and strobe path had different synchronizer depths would latch that later value instead of the one held during the strobe.

It checks `ibf` both mid-read and after the read ends. A design that cleared the flag on the read's falling edge would show low too early.

It also exercises these cases:
- It splits a write so that `intr` is checked between the two strobe edges.
- It reads status while an input request is pending, to catch a design that clears the request on any read rather than only on a data read.
- It clears one enable while both requests are pending, to show that a design which clears both, or ignores the command, gets `intr` wrong.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  // strobe vector lanes
  localparam int LN_WR  = 0;
  localparam int LN_RD  = 1;
  localparam int LN_STB = 2;
  localparam int LN_ACK = 3;
  localparam int N_LANES = 4;

  // status byte fields
  localparam int ST_OBF = 7;
  localparam int ST_OIE = 6;
  localparam int ST_IBF = 5;
  localparam int ST_IIE = 4;
  localparam int ST_IRQ = 3;

  // command word fields
  localparam int CMD_VAL = 0;
  localparam int CMD_SEL = 1;

  localparam logic ADR_DATA = 1'b0;
  localparam logic ADR_CTRL = 1'b1;

  typedef struct packed {
    logic level;
    logic fall;
    logic rise;
  } edge_t;
endpackage

// File: rtl/bhp_sync.sv
module bhp_sync #(
  parameter int                 W       = 4,
  parameter int                 STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bhp_out_side.sv
module bhp_out_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [DW-1:0] wdata,
  input  bhp_pkg::edge_t ack,
  input  logic          inte,
  output logic [DW-1:0] latch,
  output logic          obf_n,
  output logic          oe,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      obf_n <= 1'b1;
      oe    <= 1'b0;
      req   <= 1'b0;
    end else begin
      oe <= ~ack.level;
      if (wr_rise) begin
        latch <= wdata;
        obf_n <= 1'b0;
      end else if (ack.fall) begin
        obf_n <= 1'b1;
      end
      if (wr_fall || !inte)          req <= 1'b0;
      else if (ack.rise && obf_n)    req <= 1'b1;
    end
  end
endmodule

// File: rtl/bhp_in_side.sv
module bhp_in_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pins,
  input  bhp_pkg::edge_t stb,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          inte,
  output logic [DW-1:0] latch,
  output logic          ibf,
  output logic          req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      ibf   <= 1'b0;
      req   <= 1'b0;
    end else begin
      if (!stb.level) latch <= pins;
      if (stb.fall)     ibf <= 1'b1;
      else if (rd_rise) ibf <= 1'b0;
      if (rd_fall || !inte)       req <= 1'b0;
      else if (stb.rise && ibf)   req <= 1'b1;
    end
  end
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_addr,
  input  logic          cpu_wr_n,
  input  logic          cpu_rd_n,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  input  logic          ack_n,
  input  logic          stb_n,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr
);
  import bhp_pkg::*;

  localparam int NL = N_LANES;

  logic [NL-1:0] raw_s, sync_s, prev_s, fall_s, rise_s;
  logic [DW-1:0] pins_s;

  assign raw_s[LN_WR]  = cpu_wr_n;
  assign raw_s[LN_RD]  = cpu_rd_n;
  assign raw_s[LN_STB] = stb_n;
  assign raw_s[LN_ACK] = ack_n;

  bhp_sync #(.W(NL), .STAGES(SYNC_STAGES), .RST_VAL({NL{1'b1}})) u_strb_sync (
    .clk(clk), .rst(rst), .d(raw_s), .q(sync_s));

  bhp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL({DW{1'b0}})) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s));

  always_ff @(posedge clk) begin
    if (rst) prev_s <= '1;
    else     prev_s <= sync_s;
  end

  assign fall_s = prev_s & ~sync_s;
  assign rise_s = ~prev_s & sync_s;

  edge_t ack_e, stb_e;
  assign ack_e = '{level: sync_s[LN_ACK], fall: fall_s[LN_ACK], rise: rise_s[LN_ACK]};
  assign stb_e = '{level: sync_s[LN_STB], fall: fall_s[LN_STB], rise: rise_s[LN_STB]};

  logic wr_dat_rise, wr_dat_fall, wr_ctl_rise, rd_dat_fall, rd_dat_rise, rd_any_fall;
  assign wr_dat_rise = rise_s[LN_WR] && (cpu_addr == ADR_DATA);
  assign wr_dat_fall = fall_s[LN_WR] && (cpu_addr == ADR_DATA);
  assign wr_ctl_rise = rise_s[LN_WR] && (cpu_addr == ADR_CTRL);
  assign rd_dat_fall = fall_s[LN_RD] && (cpu_addr == ADR_DATA);
  assign rd_dat_rise = rise_s[LN_RD] && (cpu_addr == ADR_DATA);
  assign rd_any_fall = fall_s[LN_RD];

  // interrupt enables
  logic inte_out, inte_in;
  always_ff @(posedge clk) begin
    if (rst) begin
      inte_out <= 1'b0;
      inte_in  <= 1'b0;
    end else if (wr_ctl_rise) begin
      if (cpu_wdata[CMD_SEL]) inte_in  <= cpu_wdata[CMD_VAL];
      else                    inte_out <= cpu_wdata[CMD_VAL];
    end
  end

  logic [DW-1:0] out_latch, in_latch;
  logic          out_req, in_req;

  bhp_out_side #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .wr_rise(wr_dat_rise), .wr_fall(wr_dat_fall),
    .wdata(cpu_wdata), .ack(ack_e), .inte(inte_out),
    .latch(out_latch), .obf_n(obf_n), .oe(pin_oe), .req(out_req));

  bhp_in_side #(.DW(DW)) u_in (
    .clk(clk), .rst(rst), .pins(pins_s), .stb(stb_e),
    .rd_fall(rd_dat_fall), .rd_rise(rd_dat_rise), .inte(inte_in),
    .latch(in_latch), .ibf(ibf), .req(in_req));

  assign pin_out = out_latch;
  assign intr    = out_req | in_req;

  logic [DW-1:0] status;
  always_comb begin
    status         = '0;
    status[ST_OBF] = obf_n;
    status[ST_OIE] = inte_out;
    status[ST_IBF] = ibf;
    status[ST_IIE] = inte_in;
    status[ST_IRQ] = intr;
  end

  always_ff @(posedge clk) begin
    if (rst)              cpu_rdata <= '0;
    else if (rd_any_fall) cpu_rdata <= (cpu_addr == ADR_CTRL) ? status : in_latch;
  end
endmodule

// File: rtl/bhp_chk.sv
module bhp_chk (
  input logic clk,
  input logic rst,
  input logic obf_n,
  input logic ibf,
  input logic intr,
  input logic pin_oe,
  input logic wr_dat_rise,
  input logic ack_fall,
  input logic stb_fall,
  input logic inte_out,
  input logic inte_in
);
  AST_OBF_LOW_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(obf_n) |-> $past(wr_dat_rise)); // R1
  AST_OBF_HIGH_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(obf_n) |-> $past(ack_fall)); // R2
  AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_oe) |-> $past(ack_fall)); // R3
  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(stb_fall)); // R5
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!inte_out && !inte_in) |=> !intr); // R8
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (obf_n && !ibf && !intr && !pin_oe)); // R10
endmodule

bind bidir_hs_port bhp_chk u_chk (
  .clk(clk), .rst(rst), .obf_n(obf_n), .ibf(ibf), .intr(intr), .pin_oe(pin_oe),
  .wr_dat_rise(wr_dat_rise), .ack_fall(fall_s[bhp_pkg::LN_ACK]),
  .stb_fall(fall_s[bhp_pkg::LN_STB]), .inte_out(inte_out), .inte_in(inte_in));

// File: tb/sim_bidir_hs_port.sv
`timescale 1ns/1ps
module sim_bidir_hs_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_addr = 1'b0;
  logic       cpu_wr_n = 1'b1;
  logic       cpu_rd_n = 1'b1;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic       pin_oe;
  logic       ack_n = 1'b1;
  logic       stb_n = 1'b1;
  logic       obf_n, ibf, intr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bidir_hs_port u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .ack_n(ack_n), .stb_n(stb_n), .obf_n(obf_n), .ibf(ibf), .intr(intr));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic ob, input logic oie, input logic ib,
                                      input logic iie, input logic irq);
    return {ob, oie, ib, iie, irq, 3'b000};
  endfunction

  task automatic wr_bus(input logic a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; tick(1);
    cpu_wr_n = 1'b0; tick(5);
    cpu_wr_n = 1'b1; tick(5);
  endtask

  task automatic rd_bus(input logic a, output logic [7:0] d);
    cpu_addr = a; tick(1);
    cpu_rd_n = 1'b0; tick(5);
    d = cpu_rdata;
    cpu_rd_n = 1'b1; tick(5);
  endtask

  task automatic ack_pulse();
    ack_n = 1'b0; tick(5);
    ack_n = 1'b1; tick(5);
  endtask

  task automatic stb_pulse(input logic [7:0] v);
    pin_in = v; tick(1);
    stb_n = 1'b0; tick(5);
    stb_n = 1'b1; pin_in = ~v; tick(5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] r;
    tick(4); rst = 1'b0; tick(2);

    // R10 reset state
    chk("R10 obf_n", {7'd0, obf_n}, 8'h01);
    chk("R10 ibf", {7'd0, ibf}, 8'h00);
    chk("R10 intr", {7'd0, intr}, 8'h00);
    chk("R10 pin_oe", {7'd0, pin_oe}, 8'h00);
    rd_bus(1'b1, r); chk("R10 R9 status", r, 8'h80);

    // R1 R2 R3 output path, enables off
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'(k * 37 + 5);
      wr_bus(1'b0, d);
      chk("R1 obf_n low", {7'd0, obf_n}, 8'h00);
      chk("R3 idle float", {7'd0, pin_oe}, 8'h00);
      ack_n = 1'b0; tick(5);
      chk("R3 drive", {7'd0, pin_oe}, 8'h01);
      chk("R3 pin_out", pin_out, d);
      chk("R2 obf_n high", {7'd0, obf_n}, 8'h01);
      ack_n = 1'b1; tick(5);
      chk("R3 release", {7'd0, pin_oe}, 8'h00);
      chk("R6 no irq disabled", {7'd0, intr}, 8'h00);
    end

    // R6 R8 R9 output interrupt
    wr_bus(1'b1, 8'h01);
    rd_bus(1'b1, r); chk("R8 R9 status out enable", r, stat(1, 1, 0, 0, 0));
    wr_bus(1'b0, 8'h3C); ack_pulse();
    chk("R6 irq set", {7'd0, intr}, 8'h01);
    rd_bus(1'b1, r); chk("R9 status irq", r, stat(1, 1, 0, 0, 1));
    cpu_addr = 1'b0; cpu_wdata = 8'h5A; tick(1);
    cpu_wr_n = 1'b0; tick(5);
    chk("R6 irq cleared on write fall", {7'd0, intr}, 8'h00);
    chk("R1 obf_n waits for rise", {7'd0, obf_n}, 8'h01);
    cpu_wr_n = 1'b1; tick(5);
    chk("R1 obf_n low after rise", {7'd0, obf_n}, 8'h00);
    ack_n = 1'b0; tick(5);
    chk("R3 new data", pin_out, 8'h5A);
    ack_n = 1'b1; tick(5);
    chk("R6 irq again", {7'd0, intr}, 8'h01);
    wr_bus(1'b1, 8'h00);
    chk("R8 clear enable drops irq", {7'd0, intr}, 8'h00);
    rd_bus(1'b1, r); chk("R9 status idle", r, stat(1, 0, 0, 0, 0));

    // R4 R5 input path, enables off
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v, v2;
      v = 8'(k * 41 + 3); v2 = ~v ^ 8'(k);
      pin_in = v; tick(1);
      stb_n = 1'b0; tick(5);
      chk("R5 ibf rise", {7'd0, ibf}, 8'h01);
      pin_in = v2; tick(5);
      stb_n = 1'b1; pin_in = 8'hA5 ^ v; tick(5);
      chk("R5 ibf held", {7'd0, ibf}, 8'h01);
      chk("R7 no irq disabled", {7'd0, intr}, 8'h00);
      cpu_addr = 1'b0; tick(1);
      cpu_rd_n = 1'b0; tick(5);
      chk("R4 read captured", cpu_rdata, v2);
      chk("R5 ibf through read", {7'd0, ibf}, 8'h01);
      cpu_rd_n = 1'b1; tick(5);
      chk("R5 ibf fall", {7'd0, ibf}, 8'h00);
    end

    // R7 input interrupt
    wr_bus(1'b1, 8'h03);
    stb_pulse(8'h77);
    chk("R7 irq set", {7'd0, intr}, 8'h01);
    rd_bus(1'b1, r); chk("R9 status input side", r, stat(1, 0, 1, 1, 1));
    chk("R7 status read keeps irq", {7'd0, intr}, 8'h01);
    cpu_addr = 1'b0; tick(1);
    cpu_rd_n = 1'b0; tick(5);
    chk("R7 irq cleared on read fall", {7'd0, intr}, 8'h00);
    chk("R4 data", cpu_rdata, 8'h77);
    cpu_rd_n = 1'b1; tick(5);

    // R8 two requests, one line
    wr_bus(1'b1, 8'h01);
    wr_bus(1'b0, 8'h11); ack_pulse();
    stb_pulse(8'h22);
    chk("R8 both pending", {7'd0, intr}, 8'h01);
    wr_bus(1'b1, 8'h02);
    chk("R8 output request remains", {7'd0, intr}, 8'h01);
    rd_bus(1'b1, r); chk("R9 status mixed", r, stat(1, 1, 1, 0, 1));
    wr_bus(1'b1, 8'h00);
    chk("R8 none pending", {7'd0, intr}, 8'h00);

    // R10 reset mid-operation
    wr_bus(1'b1, 8'h03);
    wr_bus(1'b0, 8'hFF);
    stb_pulse(8'h99);
    rst = 1'b1; tick(2); rst = 1'b0; tick(2);
    chk("R10 obf_n after reset", {7'd0, obf_n}, 8'h01);
    chk("R10 ibf after reset", {7'd0, ibf}, 8'h00);
    chk("R10 intr after reset", {7'd0, intr}, 8'h00);
    rd_bus(1'b1, r); chk("R10 status after reset", r, 8'h80);
    rd_bus(1'b0, r); chk("R10 input cleared", r, 8'h00);
    ack_n = 1'b0; tick(5);
    chk("R10 output cleared", pin_out, 8'h00);
    ack_n = 1'b1; tick(5);

    finish_run();
  end
endmodule